// File: doc/BRIEF.md
# DSP Data Address Generator

This block produces the 16-bit data-memory address for a 16-bit fixed-point DSP core. It offers two ways of forming that address. In direct mode a 9-bit page register supplies the upper bits and the seven least significant bits of the instruction word supply the lower bits. In indirect mode a 3-bit pointer picks one of eight 16-bit auxiliary registers, and that register's value becomes the address.

After an indirect access, a dedicated 16-bit arithmetic unit can modify the register that was just used. It can step the register up or down by one, or add or subtract auxiliary register 0. All of these changes wrap modulo 2^16. Whenever the pointer is reloaded, its old value is kept in a 3-bit backup register.

The instruction decoder drives the mode, the access strobe and the update code. The address output is combinational, so it can be registered by the memory side.

Top module: `data_addr_gen`

## Requirements
- R1: Reset (rst_ni low) clears the page register, all eight auxiliary registers, the pointer and the backup register to zero.
- R2: With mode_i=0 (direct), addr_o equals {page register, insn_i[6:0]}. insn_i[15:7] has no effect on the address.
- R3: A page load (page_ld_i=1) takes effect at the next rising clock edge. Without a load, the page register holds its value.
- R4: With mode_i=1 (indirect), addr_o equals the auxiliary register selected by the pointer, as it was before any update in the same cycle.
- R5: An auxiliary register load (ar_ld_i=1, register ar_sel_i) takes effect at the next edge. When a load and an update target the same register in the same cycle, the load wins.
- R6: When mode_i=1 and acc_en_i=1, the selected register is updated at the edge according to upd_op_i: 0 leaves it unchanged, 1 adds 1, 2 subtracts 1, 3 adds AR0, 4 subtracts AR0. Codes 5 to 7 leave it unchanged.
- R7: Every update wraps modulo 2^16. For example, 0xFFFF+1 gives 0x0000, and 0x0005-0x0010 gives 0xFFF5.
- R8: When ptr_ld_i=1, ptr_o takes ptr_d_i at the next edge and ptr_bkp_o takes the old pointer at the same edge. This happens even if the value is reloaded unchanged. Without a load, both hold.
- R9: No auxiliary register changes in direct mode, or in indirect mode with acc_en_i=0, even if upd_op_i requests an update.
- R10: When the pointer selects AR0 and code 3 is applied, AR0 doubles, because it is added to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = direct, 1 = indirect |
| acc_en_i | input | 1 | Access strobe that enables the post-access update |
| upd_op_i | input | 3 | Post-access update code |
| insn_i | input | 16 | Instruction word; bits 6:0 form the direct offset |
| page_ld_i | input | 1 | Page register load enable |
| page_d_i | input | 9 | Page register load value |
| ar_ld_i | input | 1 | Auxiliary register load enable |
| ar_sel_i | input | 3 | Auxiliary register to load |
| ar_d_i | input | 16 | Auxiliary register load value |
| ptr_ld_i | input | 1 | Pointer load enable |
| ptr_d_i | input | 3 | Pointer load value |
| addr_o | output | 16 | Data-memory address |
| ptr_o | output | 3 | Current pointer |
| ptr_bkp_o | output | 3 | Backup copy of the previous pointer |

## Verification
The hardest case to reach from the ports is two writes to one auxiliary register in the same cycle: an explicit load and an arithmetic update. It only arises when the pointer already selects the register named by ar_sel_i while an indirect access is requested. The stimulus first moves the pointer with a load, then drives a load and an increment to that register together, and reads the winner back as the next indirect address. The wrap cases are set up by loading 0xFFFF or a small value, and the AR0 self-add case by loading the pointer with zero.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned NUM_AR = 8;
  localparam int unsigned PTR_W  = $clog2(NUM_AR);
  localparam int unsigned PAGE_W = 9;
  localparam int unsigned OFFS_W = DATA_W - PAGE_W;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    UPD_NONE = 3'd0,
    UPD_INC  = 3'd1,
    UPD_DEC  = 3'd2,
    UPD_ADD0 = 3'd3,
    UPD_SUB0 = 3'd4
  } upd_op_e;
endpackage

// File: rtl/dag_aux_alu.sv
module dag_aux_alu #(
  parameter int unsigned W    = dag_pkg::DATA_W,
  parameter int unsigned OP_W = dag_pkg::OP_W
) (
  input  logic [W-1:0]    cur_i,
  input  logic [W-1:0]    idx_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    nxt_o,
  output logic            upd_o
);
  import dag_pkg::*;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    nxt_o = cur_i;
    upd_o = 1'b1;
    case (op_i)
      UPD_INC:  nxt_o = cur_i + ONE;
      UPD_DEC:  nxt_o = cur_i - ONE;
      UPD_ADD0: nxt_o = cur_i + idx_i;
      UPD_SUB0: nxt_o = cur_i - idx_i;
      default:  upd_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dag_ar_bank.sv
module dag_ar_bank #(
  parameter int unsigned W  = dag_pkg::DATA_W,
  parameter int unsigned N  = dag_pkg::NUM_AR,
  parameter int unsigned PW = dag_pkg::PTR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [PW-1:0] ld_sel_i,
  input  logic [W-1:0]  ld_data_i,
  input  logic          upd_i,
  input  logic [PW-1:0] upd_sel_i,
  input  logic [W-1:0]  upd_data_i,
  input  logic [PW-1:0] rd_sel_i,
  output logic [W-1:0]  rd_data_o,
  output logic [W-1:0]  ar0_o
);
  logic [W-1:0] ar_w [N];

  for (genvar i = 0; i < N; i++) begin : g_ar
    logic [W-1:0] q;
    logic         hit_ld, hit_upd;
    assign hit_ld  = ld_i  && (ld_sel_i  == PW'(i));
    assign hit_upd = upd_i && (upd_sel_i == PW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (hit_ld)  q <= ld_data_i;   // load wins over update
      else if (hit_upd) q <= upd_data_i;
    end
    assign ar_w[i] = q;
  end

  assign rd_data_o = ar_w[rd_sel_i];
  assign ar0_o     = ar_w[0];
endmodule

// File: rtl/dag_ptr_ctrl.sv
module dag_ptr_ctrl #(
  parameter int unsigned PW = dag_pkg::PTR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [PW-1:0] d_i,
  output logic [PW-1:0] ptr_o,
  output logic [PW-1:0] bkp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      bkp_o <= '0;
    end else if (ld_i) begin
      bkp_o <= ptr_o;
      ptr_o <= d_i;
    end
  end
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode_i,
  input  logic        acc_en_i,
  input  logic [2:0]  upd_op_i,
  input  logic [15:0] insn_i,
  input  logic        page_ld_i,
  input  logic [8:0]  page_d_i,
  input  logic        ar_ld_i,
  input  logic [2:0]  ar_sel_i,
  input  logic [15:0] ar_d_i,
  input  logic        ptr_ld_i,
  input  logic [2:0]  ptr_d_i,
  output logic [15:0] addr_o,
  output logic [2:0]  ptr_o,
  output logic [2:0]  ptr_bkp_o
);
  import dag_pkg::*;

  logic [PAGE_W-1:0] page_q;
  logic [DATA_W-1:0] ar_rd, ar0, ar_nxt;
  logic              alu_upd, do_upd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        page_q <= '0;
    else if (page_ld_i) page_q <= page_d_i;
  end

  dag_ptr_ctrl #(.PW(PTR_W)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (ptr_ld_i),
    .d_i   (ptr_d_i),
    .ptr_o (ptr_o),
    .bkp_o (ptr_bkp_o)
  );

  dag_aux_alu #(.W(DATA_W), .OP_W(OP_W)) u_alu (
    .cur_i(ar_rd),
    .idx_i(ar0),
    .op_i (upd_op_i),
    .nxt_o(ar_nxt),
    .upd_o(alu_upd)
  );

  assign do_upd = mode_i && acc_en_i && alu_upd;

  dag_ar_bank #(.W(DATA_W), .N(NUM_AR), .PW(PTR_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (ar_ld_i),
    .ld_sel_i  (ar_sel_i),
    .ld_data_i (ar_d_i),
    .upd_i     (do_upd),
    .upd_sel_i (ptr_o),
    .upd_data_i(ar_nxt),
    .rd_sel_i  (ptr_o),
    .rd_data_o (ar_rd),
    .ar0_o     (ar0)
  );

  assign addr_o = mode_i ? ar_rd : {page_q, insn_i[OFFS_W-1:0]};
endmodule

// File: rtl/dag_checker.sv
module dag_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mode_i,
  input logic        acc_en_i,
  input logic [2:0]  upd_op_i,
  input logic        page_ld_i,
  input logic        ar_ld_i,
  input logic        ptr_ld_i,
  input logic [2:0]  ptr_d_i,
  input logic [15:0] addr_o,
  input logic [2:0]  ptr_o,
  input logic [2:0]  ptr_bkp_o
);
  logic quiet;
  assign quiet = !ar_ld_i && !ptr_ld_i;

  assert_bkp_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_ld_i |=> (ptr_bkp_o == $past(ptr_o)) && (ptr_o == $past(ptr_d_i)));

  assert_ptr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ptr_ld_i |=> $stable(ptr_o) && $stable(ptr_bkp_o));

  assert_page_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !page_ld_i) |=> (mode_i || addr_o[15:7] == $past(addr_o[15:7])));

  assert_inc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && acc_en_i && upd_op_i == 3'd1 && quiet) |=>
      (!mode_i || addr_o == 16'($past(addr_o) + 16'd1)));

  assert_dec_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && acc_en_i && upd_op_i == 3'd2 && quiet) |=>
      (!mode_i || addr_o == 16'($past(addr_o) - 16'd1)));

  assert_no_access_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !acc_en_i && quiet) |=> (!mode_i || $stable(addr_o)));
endmodule

bind data_addr_gen dag_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .acc_en_i (acc_en_i),
  .upd_op_i (upd_op_i),
  .page_ld_i(page_ld_i),
  .ar_ld_i  (ar_ld_i),
  .ptr_ld_i (ptr_ld_i),
  .ptr_d_i  (ptr_d_i),
  .addr_o   (addr_o),
  .ptr_o    (ptr_o),
  .ptr_bkp_o(ptr_bkp_o)
);

// File: tb/data_addr_gen_bench.sv
module data_addr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0, acc_en_i = 1'b0, page_ld_i = 1'b0, ar_ld_i = 1'b0, ptr_ld_i = 1'b0;
  logic [2:0]  upd_op_i = '0, ar_sel_i = '0, ptr_d_i = '0;
  logic [15:0] insn_i = '0, ar_d_i = '0;
  logic [8:0]  page_d_i = '0;
  logic [15:0] addr_o;
  logic [2:0]  ptr_o, ptr_bkp_o;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  data_addr_gen u_data_addr_gen (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .acc_en_i(acc_en_i),
    .upd_op_i(upd_op_i), .insn_i(insn_i), .page_ld_i(page_ld_i), .page_d_i(page_d_i),
    .ar_ld_i(ar_ld_i), .ar_sel_i(ar_sel_i), .ar_d_i(ar_d_i), .ptr_ld_i(ptr_ld_i),
    .ptr_d_i(ptr_d_i), .addr_o(addr_o), .ptr_o(ptr_o), .ptr_bkp_o(ptr_bkp_o)
  );

  typedef struct packed {
    logic mode; logic acc; logic [2:0] op;
    logic pld; logic [2:0] pd;
    logic ald; logic [2:0] asel; logic [15:0] ad;
    logic gld; logic [8:0] gd;
    logic [15:0] insn; logic [15:0] exp; logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0,16'h0000, 1'b1,9'h1A5, 16'h0033,16'h0033,4'd2}, // R2 page load pending
    '{1'b0,1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0,16'h0000, 1'b0,9'h000, 16'hFF55,16'hD2D5,4'd2}, // R2 upper insn ignored
    '{1'b0,1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd0,16'h0010, 1'b0,9'h000, 16'h0000,16'hD280,4'd3}, // R3 page held
    '{1'b1,1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd3,16'h1000, 1'b0,9'h000, 16'h0000,16'h0010,4'd4}, // R4 AR0
    '{1'b1,1'b0,3'd0, 1'b1,3'd3, 1'b0,3'd0,16'h0000, 1'b0,9'h000, 16'h0000,16'h0010,4'd8}, // R8 old ptr this cycle
    '{1'b1,1'b1,3'd1, 1'b0,3'd0, 1'b0,3'd0,16'h0000, 1'b0,9'h000, 16'h0000,16'h1000,4'd4}, // R4 pre-update value
    '{1'b1,1'b1,3'd3, 1'b0,3'd0, 1'b0,3'd0,16'h0000, 1'b0,9'h000, 16'h0000,16'h1001,4'd6}, // R6 +1 seen
    '{1'b1,1'b1,3'd4, 1'b0,3'd0, 1'b0,3'd0,16'h0000, 1'b0,9'h000, 16'h0000,16'h1011,4'd6}, // R6 +AR0 seen
    '{1'b1,1'b1,3'd2, 1'b0,3'd0, 1'b0,3'd0,16'h0000, 1'b0,9'h000, 16'h0000,16'h1001,4'd6}, // R6 -AR0 seen
    '{1'b1,1'b1,3'd5, 1'b0,3'd0, 1'b0,3'd0,16'h0000, 1'b0,9'h000, 16'h0000,16'h1000,4'd6}, // R6 -1 seen
    '{1'b0,1'b1,3'd1, 1'b0,3'd0, 1'b0,3'd0,16'h0000, 1'b0,9'h000, 16'h007F,16'hD2FF,4'd9}, // R6 code 5 no-op, R9 direct
    '{1'b1,1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0,16'h0000, 1'b0,9'h000, 16'h0000,16'h1000,4'd9}  // R9 unchanged
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    mode_i = 0; acc_en_i = 0; upd_op_i = 0; insn_i = 0; page_ld_i = 0; page_d_i = 0;
    ar_ld_i = 0; ar_sel_i = 0; ar_d_i = 0; ptr_ld_i = 0; ptr_d_i = 0;
  endtask

  task automatic next();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      finish_run();
    end
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    insn_i = 16'h0045; #1;
    chk("R1 reset addr", addr_o, 16'h0045);
    chk("R1 reset ptr", {13'd0, ptr_o}, 16'd0);
    chk("R1 reset bkp", {13'd0, ptr_bkp_o}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode_i = VEC[i].mode; acc_en_i = VEC[i].acc; upd_op_i = VEC[i].op;
      ptr_ld_i = VEC[i].pld; ptr_d_i = VEC[i].pd;
      ar_ld_i = VEC[i].ald; ar_sel_i = VEC[i].asel; ar_d_i = VEC[i].ad;
      page_ld_i = VEC[i].gld; page_d_i = VEC[i].gd; insn_i = VEC[i].insn;
      #1;
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), addr_o, VEC[i].exp);
    end
    next();
    chk("R8 ptr after load", {13'd0, ptr_o}, 16'd3);
    chk("R8 bkp after load", {13'd0, ptr_bkp_o}, 16'd0);

    // ptr -> 5, AR5 <= FFFF
    ptr_ld_i = 1; ptr_d_i = 5; ar_ld_i = 1; ar_sel_i = 5; ar_d_i = 16'hFFFF;
    next();
    chk("R8 ptr new", {13'd0, ptr_o}, 16'd5);
    chk("R8 bkp old", {13'd0, ptr_bkp_o}, 16'd3);
    mode_i = 1; acc_en_i = 1; upd_op_i = 1; #1;
    chk("R4 AR5 before inc", addr_o, 16'hFFFF);
    next();
    mode_i = 1; acc_en_i = 1; upd_op_i = 2; #1;
    chk("R7 inc wrap", addr_o, 16'h0000);
    next();
    mode_i = 1; #1;
    chk("R7 dec wrap", addr_o, 16'hFFFF);

    ptr_ld_i = 1; ptr_d_i = 5;
    next();
    chk("R8 reload same", {13'd0, ptr_bkp_o}, 16'd5);

    // load and update on same register
    mode_i = 1; acc_en_i = 1; upd_op_i = 1; ar_ld_i = 1; ar_sel_i = 5; ar_d_i = 16'h1234;
    next();
    mode_i = 1; #1;
    chk("R5 load beats update", addr_o, 16'h1234);

    ar_ld_i = 1; ar_sel_i = 5; ar_d_i = 16'h0005;
    next();
    mode_i = 1; acc_en_i = 1; upd_op_i = 4;
    next();
    mode_i = 1; #1;
    chk("R7 sub AR0 wrap", addr_o, 16'hFFF5);

    ptr_ld_i = 1; ptr_d_i = 0;
    next();
    mode_i = 1; acc_en_i = 1; upd_op_i = 3; #1;
    chk("R10 AR0 before", addr_o, 16'h0010);
    next();
    mode_i = 1; #1;
    chk("R10 AR0 doubled", addr_o, 16'h0020);
    chk("R8 bkp five", {13'd0, ptr_bkp_o}, 16'd5);

    // mid-run reset
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    mode_i = 1; #1;
    chk("R1 AR0 cleared", addr_o, 16'h0000);
    chk("R1 bkp cleared", {13'd0, ptr_bkp_o}, 16'd0);
    mode_i = 0; insn_i = 16'h0012; #1;
    chk("R1 page cleared", addr_o, 16'h0012);
    ptr_ld_i = 1; ptr_d_i = 3;
    next();
    mode_i = 1; #1;
    chk("R1 AR3 cleared", addr_o, 16'h0000);

    finish_run();
  end
endmodule